// File: doc/BRIEF.md
# Legacy Graphics Access Trap

This block sits beside a processor's bus and watches each memory and I/O transaction. When software writes into one of the three legacy graphics memory windows, or reads or writes one of the three legacy graphics I/O port groups, and trapping for that area is enabled, the block raises a one-cycle system management interrupt request. Along with the request it gives a 3-bit code that names the matching area. The interrupt handler can then emulate the display hardware.

Each trapped area has its own enable bit in a control register. A 32-bit suppression mask divides the 64 KB graphics window at A0000h into 2 KB slices. A set bit stops traps in its slice, so writes to a back buffer that is not shown on screen cost no interrupt. The mask acts only on that window. It has no effect on the other areas, and none at all while the window's own enable is clear. Memory reads never trap.

Top module: `vga_trap_smi`

## Requirements
- R1: A valid memory write (bus_is_io=0, bus_write=1) whose enable bit is set raises smi_req in the cycle after the transaction, with one range code per window: A0000h..AFFFFh gives code 0, B0000h..B7FFFh gives code 1, B8000h..BFFFFh gives code 2. The full address is compared, so upper bits must be zero.
- R2: A valid memory read (bus_is_io=0, bus_write=0) never raises smi_req, whatever the address or the register contents.
- R3: A valid I/O access (bus_is_io=1), read or write, traps in these port groups when enabled: 3B0h..3BFh gives code 3, 3C0h..3CFh gives code 4, 3D0h..3DFh gives code 5.
- R4: Control register bit k (k = 0..5) enables the area with range code k. A clear bit prevents any trap in that area. A register write with cfg_sel=0 loads bits [5:0] of cfg_wdata into the control register; cfg_sel=1 loads all 32 bits into the mask.
- R5: Mask bit n covers the addresses A0000h + n*800h through A0000h + n*800h + 7FFh, so address bits [15:11] select the bit. A 1 in that bit suppresses the trap for a write in that slice.
- R6: The mask has no effect on the B0000h and B8000h windows or on any I/O port group.
- R7: While control bit 0 is clear, writes to the A0000h window never trap, whatever the mask holds.
- R8: After reset both registers are zero, smi_req is 0 and smi_range is 0. No access traps until software enables an area.
- R9: smi_req is high for exactly one cycle per matching transaction. No request is raised in a cycle after one with bus_valid low, or for an address outside all six areas.
- R10: A register write in the same cycle as a transaction takes effect from the next cycle. The transaction is judged against the register contents held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A transaction is presented this cycle |
| bus_addr | input | ADDR_W | Byte address of the transaction |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control register, 1 = slice mask |
| cfg_wdata | input | 32 | Register write data |
| smi_req | output | 1 | One-cycle interrupt request |
| smi_range | output | 3 | Code of the area that matched (0..5) |

## Verification
A register write and a bus transaction can arrive in the same cycle. When they do, the outcome depends on whether the transaction sees the old or the new control and mask values. The bench provokes this on purpose: it writes an enable or a mask bit in the very cycle of an access that the change would affect. It also does so at random during the mixed run. Its reference model judges the access against the contents held before the write, and applies the new value only to later accesses.

// File: rtl/vga_trap_pkg.sv
package vga_trap_pkg;

  localparam int NUM_AREAS = 6;
  localparam int CODE_W    = 3;

  typedef enum logic [CODE_W-1:0] {
    AREA_GFX_WIN   = 3'd0,
    AREA_MONO_WIN  = 3'd1,
    AREA_COLOR_WIN = 3'd2,
    AREA_IO_MONO   = 3'd3,
    AREA_IO_ATTR   = 3'd4,
    AREA_IO_COLOR  = 3'd5
  } area_code_e;

  // Lowest address of area k
  function automatic logic [31:0] area_lo(input int k);
    case (k)
      0:       return 32'h000A_0000;
      1:       return 32'h000B_0000;
      2:       return 32'h000B_8000;
      3:       return 32'h0000_03B0;
      4:       return 32'h0000_03C0;
      default: return 32'h0000_03D0;
    endcase
  endfunction

  // Highest address of area k
  function automatic logic [31:0] area_hi(input int k);
    case (k)
      0:       return 32'h000A_FFFF;
      1:       return 32'h000B_7FFF;
      2:       return 32'h000B_FFFF;
      3:       return 32'h0000_03BF;
      4:       return 32'h0000_03CF;
      default: return 32'h0000_03DF;
    endcase
  endfunction

  function automatic logic area_is_io(input int k);
    return (k >= 3);
  endfunction

  // Lowest set bit wins; the areas are disjoint so at most one is set.
  function automatic logic [CODE_W-1:0] encode_area(input logic [NUM_AREAS-1:0] hits);
    logic [CODE_W-1:0] code;
    code = '0;
    for (int k = NUM_AREAS - 1; k >= 0; k--) begin
      if (hits[k]) code = CODE_W'(k);
    end
    return code;
  endfunction

endpackage

// File: rtl/vga_trap_regs.sv
module vga_trap_regs #(
  parameter int CTL_W  = 6,
  parameter int MASK_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [MASK_W-1:0] mask_q
);

  logic ctl_we;
  logic mask_we;

  assign ctl_we  = wr_en && !sel_mask;
  assign mask_we = wr_en &&  sel_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= wdata[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= wdata[MASK_W-1:0];
    end
  end

endmodule

// File: rtl/vga_trap_decode.sv
module vga_trap_decode
  import vga_trap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 bus_valid,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_write,
  input  logic                 bus_is_io,
  output logic [NUM_AREAS-1:0] raw_hit
);

  for (genvar k = 0; k < NUM_AREAS; k++) begin : g_area
    localparam logic [ADDR_W-1:0] LO    = ADDR_W'(area_lo(k));
    localparam logic [ADDR_W-1:0] HI    = ADDR_W'(area_hi(k));
    localparam logic              IS_IO = area_is_io(k);

    logic space_ok;
    logic dir_ok;
    logic in_span;

    assign space_ok = (bus_is_io == IS_IO);
    // memory areas trap writes only; I/O areas trap both directions
    assign dir_ok   = IS_IO ? 1'b1 : bus_write;
    assign in_span  = (bus_addr >= LO) && (bus_addr <= HI);
    assign raw_hit[k] = bus_valid && space_ok && dir_ok && in_span;
  end

endmodule

// File: rtl/vga_trap_slice_mask.sv
module vga_trap_slice_mask #(
  parameter int ADDR_W      = 32,
  parameter int MASK_W      = 32,
  parameter int SLICE_LOG2  = 11
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [MASK_W-1:0] mask_q,
  output logic              slice_block
);

  localparam int IDX_W = $clog2(MASK_W);

  logic [IDX_W-1:0] slice_idx;

  assign slice_idx   = bus_addr[SLICE_LOG2 +: IDX_W];
  assign slice_block = mask_q[slice_idx];

endmodule

// File: rtl/vga_trap_smi.sv
module vga_trap_smi
  import vga_trap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MASK_W     = 32,
  parameter int SLICE_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic              bus_is_io,
  input  logic              cfg_wr_en,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              smi_req,
  output logic [2:0]        smi_range
);

  logic [NUM_AREAS-1:0] ctl_q;
  logic [MASK_W-1:0]    mask_q;
  logic [NUM_AREAS-1:0] raw_hit;
  logic [NUM_AREAS-1:0] qual_hit;
  logic [NUM_AREAS-1:0] suppress_vec;
  logic                 slice_block;
  logic                 trap_now;

  vga_trap_regs #(
    .CTL_W  (NUM_AREAS),
    .MASK_W (MASK_W),
    .DATA_W (32)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .sel_mask (cfg_sel),
    .wdata    (cfg_wdata),
    .ctl_q    (ctl_q),
    .mask_q   (mask_q)
  );

  vga_trap_decode #(
    .ADDR_W (ADDR_W)
  ) u_decode (
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_write (bus_write),
    .bus_is_io (bus_is_io),
    .raw_hit   (raw_hit)
  );

  vga_trap_slice_mask #(
    .ADDR_W     (ADDR_W),
    .MASK_W     (MASK_W),
    .SLICE_LOG2 (SLICE_LOG2)
  ) u_slice (
    .bus_addr    (bus_addr),
    .mask_q      (mask_q),
    .slice_block (slice_block)
  );

  // only the graphics window listens to the slice mask
  assign suppress_vec = {{(NUM_AREAS-1){1'b0}}, slice_block};
  assign qual_hit     = raw_hit & ctl_q & ~suppress_vec;
  assign trap_now     = |qual_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_req   <= 1'b0;
      smi_range <= '0;
    end else begin
      smi_req   <= trap_now;
      smi_range <= trap_now ? encode_area(qual_hit) : '0;
    end
  end

endmodule

// File: rtl/vga_trap_checker.sv
module vga_trap_checker
  import vga_trap_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic                 bus_is_io,
  input logic [NUM_AREAS-1:0] raw_hit,
  input logic [NUM_AREAS-1:0] ctl_q,
  input logic                 slice_block,
  input logic                 smi_req,
  input logic [2:0]           smi_range
);

  assert_read_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_is_io && !bus_write) |=> !smi_req);

  assert_code_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> (smi_range < 3'd6));

  assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_hit != '0) && ((raw_hit & ctl_q) == '0)) |=> !smi_req);

  assert_slice_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit[0] && slice_block) |=> !smi_req);

  assert_mask_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_hit[5:1] & ctl_q[5:1]) != '0) |=> smi_req);

  assert_io_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_hit[5:3] & ctl_q[5:3]) != '0) |=> (smi_req && smi_range >= 3'd3));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !smi_req);

  assert_single_area_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(raw_hit));

endmodule

bind vga_trap_smi vga_trap_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_is_io   (bus_is_io),
  .raw_hit     (raw_hit),
  .ctl_q       (ctl_q),
  .slice_block (slice_block),
  .smi_req     (smi_req),
  .smi_range   (smi_range)
);

// File: tb/vga_trap_smi_tb.sv
`timescale 1ns/1ps
module vga_trap_smi_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic        bus_is_io = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        smi_req;
  logic [2:0]  smi_range;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0]  ctl_m  = '0;
  logic [31:0] mask_m = '0;

  always #2.5 clk = ~clk;

  vga_trap_smi u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_write (bus_write),
    .bus_is_io (bus_is_io),
    .cfg_wr_en (cfg_wr_en),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .smi_req   (smi_req),
    .smi_range (smi_range)
  );

  // Reference model written from the requirement text
  function automatic logic model_hit(input logic [31:0] a, input logic wr, input logic io,
                                     input logic [5:0] ctl, input logic [31:0] mask,
                                     output logic [2:0] code);
    int k;
    k = -1;
    if (io) begin
      if (a >= 32'h3B0 && a <= 32'h3BF)      k = 3;
      else if (a >= 32'h3C0 && a <= 32'h3CF) k = 4;
      else if (a >= 32'h3D0 && a <= 32'h3DF) k = 5;
    end else if (wr) begin
      if (a >= 32'hA0000 && a <= 32'hAFFFF)      k = 0;
      else if (a >= 32'hB0000 && a <= 32'hB7FFF) k = 1;
      else if (a >= 32'hB8000 && a <= 32'hBFFFF) k = 2;
    end
    code = (k < 0) ? 3'd0 : 3'(k);
    if (k < 0) return 1'b0;
    if (!ctl[k]) return 1'b0;
    if (k == 0 && mask[(a - 32'hA0000) / 32'h800]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string tag_for(input logic [31:0] a, input logic wr, input logic io);
    if (io) return "R3";
    if (!wr) return "R2";
    if (a >= 32'hA0000 && a <= 32'hAFFFF) return "R5";
    if (a >= 32'hB0000 && a <= 32'hBFFFF) return "R1";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (sel) mask_m = data; else ctl_m = data[5:0];
  endtask

  // One transaction, optionally with a register write in the same cycle
  task automatic txn(input logic [31:0] a, input logic wr, input logic io, input string tag,
                     input logic with_cfg = 1'b0, input logic csel = 1'b0,
                     input logic [31:0] cdata = '0);
    logic [2:0] ecode;
    logic       ehit;
    ehit = model_hit(a, wr, io, ctl_m, mask_m, ecode);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_write = wr; bus_is_io = io;
    if (with_cfg) begin
      cfg_wr_en = 1'b1; cfg_sel = csel; cfg_wdata = cdata;
    end
    @(negedge clk);
    bus_valid = 1'b0; cfg_wr_en = 1'b0;
    if (with_cfg) begin
      if (csel) mask_m = cdata; else ctl_m = cdata[5:0];
    end
    check(tag, {31'b0, smi_req}, {31'b0, ehit}, $sformatf("smi_req addr=%0h", a));
    if (ehit) check(tag, {29'b0, smi_range}, {29'b0, ecode}, $sformatf("smi_range addr=%0h", a));
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R9", {31'b0, smi_req}, 32'd0, "smi_req after idle cycle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check("R8", {31'b0, smi_req}, 32'd0, "smi_req in reset");
    check("R8", {29'b0, smi_range}, 32'd0, "smi_range in reset");
    rst_n = 1'b1;
    txn(32'hA0000, 1'b1, 1'b0, "R8");
    txn(32'h3C4,   1'b0, 1'b1, "R8");

    cfg_write(1'b0, 32'h3F);
    txn(32'hA0000, 1'b1, 1'b0, "R1");
    idle_check();
    txn(32'hAFFFF, 1'b0, 1'b0, "R2");
    txn(32'hB7FFF, 1'b1, 1'b0, "R1");
    txn(32'hB8000, 1'b1, 1'b0, "R1");
    txn(32'hBFFFF, 1'b1, 1'b0, "R1");
    txn(32'hC0000, 1'b1, 1'b0, "R9");
    txn(32'h9FFFF, 1'b1, 1'b0, "R9");
    txn(32'h100A0000, 1'b1, 1'b0, "R1");
    txn(32'h3B0, 1'b0, 1'b1, "R3");
    txn(32'h3CF, 1'b1, 1'b1, "R3");
    txn(32'h3DF, 1'b0, 1'b1, "R3");
    txn(32'h3E0, 1'b1, 1'b1, "R3");
    txn(32'h3AF, 1'b1, 1'b1, "R3");
    txn(32'h3C0, 1'b1, 1'b0, "R3");
    txn(32'hA0000, 1'b1, 1'b1, "R3");

    cfg_write(1'b1, 32'h0000_0001);
    txn(32'hA0000, 1'b1, 1'b0, "R5");
    txn(32'hA07FF, 1'b1, 1'b0, "R5");
    txn(32'hA0800, 1'b1, 1'b0, "R5");
    cfg_write(1'b1, 32'h8000_0000);
    txn(32'hAF800, 1'b1, 1'b0, "R5");
    txn(32'hAF7FF, 1'b1, 1'b0, "R5");
    cfg_write(1'b1, 32'hFFFF_FFFF);
    txn(32'hB0000, 1'b1, 1'b0, "R6");
    txn(32'hB8800, 1'b1, 1'b0, "R6");
    txn(32'h3C5,   1'b0, 1'b1, "R6");

    cfg_write(1'b1, 32'h0);
    cfg_write(1'b0, 32'h3E);
    txn(32'hA1000, 1'b1, 1'b0, "R7");
    cfg_write(1'b1, 32'h5A5A_0F0F);
    txn(32'hA1000, 1'b1, 1'b0, "R7");
    txn(32'hB0010, 1'b1, 1'b0, "R4");
    cfg_write(1'b0, 32'h00);
    txn(32'h3D4, 1'b1, 1'b1, "R4");
    txn(32'hB8000, 1'b1, 1'b0, "R4");

    cfg_write(1'b1, 32'h0);
    txn(32'hA0000, 1'b1, 1'b0, "R10", 1'b1, 1'b0, 32'h3F);
    txn(32'hA0000, 1'b1, 1'b0, "R10");
    txn(32'hA0000, 1'b1, 1'b0, "R10", 1'b1, 1'b1, 32'h1);
    txn(32'hA0000, 1'b1, 1'b0, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic        wr;
      logic        io;
      int          pick;
      pick = int'($urandom % 4);
      case (pick)
        0: a = 32'hA0000 + ($urandom % 32'h20000);
        1: a = 32'h3A0 + ($urandom % 32'h50);
        2: a = $urandom;
        default: a = 32'h9FFF0 + ($urandom % 32'h20);
      endcase
      wr = $urandom % 2 == 1;
      io = (pick == 1) ? ($urandom % 8 != 0) : ($urandom % 8 == 0);
      if ($urandom % 10 == 0)
        txn(a, wr, io, "R10", 1'b1, ($urandom % 2) == 1, $urandom);
      else
        txn(a, wr, io, tag_for(a, wr, io));
      if ($urandom % 16 == 0) idle_check();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule